// File: doc/BRIEF.md
# Status register write filter

This block holds the machine-level status word of a processor core and guards every software write to it. A write passes through a legality filter field by field: enable bits and the floating-point state field always take the new value, the extension state field follows only when an extension is fitted, and each privilege field and the address-translation mode field keep their old contents when an encoding is written that the core does not support. The summary dirty bit is derived from the two state fields and cannot be written directly.

A second, narrower supervisor view of the same storage is offered both for reading and for writing. A supervisor write rearranges its fields into machine-level positions and then goes through the same filter. Whenever a write asks for a change in the translation mode, the current privilege, the previous privilege or the modified-privilege bit, a flush strobe tells the address-translation cache to drop its contents.

The write source is decoded each cycle into one of three kinds: `WR_NONE`, `WR_MACH` or `WR_SUP`. The strobe comes from a two-state machine. In `PH_QUIET` the strobe is low. The transition `PH_QUIET -> PH_FLUSH` is taken on a write that requests a translation-relevant change. `PH_FLUSH` drives the strobe high. From there it moves to `PH_FLUSH -> PH_QUIET` when the next cycle carries no such write, or stays in `PH_FLUSH -> PH_FLUSH` when the next cycle carries another such write.

Top module: `stat_filter`

## Requirements
- R1: After reset the status word reads with current privilege = 3 (machine) in bits [2:1], previous privilege = 1 (supervisor) in bits [5:4], second-previous privilege = 1 in bits [8:7], every other bit 0 (0x96), and the flush strobe low.
- R2: A machine write (`mwr_i`) copies the interrupt enable (bit 0), previous enable (bit 3), second-previous enable (bit 6), modified-privilege bit (bit 16) and FP state field (bits [13:12]) from `wdata_i` without condition. The status word shows the new value in the cycle after the strobe.
- R3: The extension state field (bits [15:14]) takes the written value only when `ext_present_i` is high in the write cycle. Otherwise it keeps its value.
- R4: Each of the three privilege fields (bits [2:1], [5:4], [8:7]) is updated independently, and only to 0 (user), 1 (supervisor) or 3 (machine). A written 2 leaves that field unchanged.
- R5: The translation mode field (bits [21:17]) accepts 0 (bare), 9 and 10 when XLEN is 64, and 0 and 8 when XLEN is 32. Any other value leaves the field unchanged.
- R6: The top bit (XLEN-1) of the status word reads 1 exactly when the FP state field or the extension state field is 3. Writing that bit, or any bit outside the defined fields, has no effect, and such bits read 0.
- R7: The flush strobe is high for one cycle, in the cycle after a write whose candidate value (before filtering) differs from the stored value in the translation mode, current privilege, previous privilege or modified-privilege field. It stays low after writes that request no such change and in cycles without a write.
- R8: A supervisor write (`swr_i`) takes its enable from bit 0, previous enable from bit 4, previous privilege from bits [9:8], FP state from [13:12], extension state from [15:14] and modified-privilege from bit 16. It maps them onto the matching machine fields and passes the result through the same filter. All other machine fields stay unchanged.
- R9: `sview_o` shows enable at bit 0, previous enable at bit 4, previous privilege at bits [9:8], FP state at [13:12], extension state at [15:14], modified-privilege at bit 16 and the dirty summary at bit XLEN-1. All other bits are 0.
- R10: When both write strobes are high in the same cycle, the machine write is applied and the supervisor write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wdata_i | input | XLEN | Write data, in machine or supervisor layout |
| mwr_i | input | 1 | Machine-layout write strobe |
| swr_i | input | 1 | Supervisor-layout write strobe |
| ext_present_i | input | 1 | An extension is fitted, so its state field is writable |
| status_o | output | XLEN | Machine status word |
| sview_o | output | XLEN | Supervisor view of the status word |
| flush_o | output | 1 | Translation-cache flush strobe |

## Verification
The bench writes the encoding 2 into the privilege fields, including a mix where one field is legal and its neighbours are not. A filter that handled the fields as a group would either take the illegal code or drop the legal one. It writes mode 8, which is legal only at the narrow width, with XLEN 64, and writes an out-of-range mode. A width check tied to the wrong parameter branch would load the mode. It writes the extension state with the extension absent and then present, writes the dirty bit directly, and writes reserved bits. This exposes a dirty summary that is stored rather than derived. For the flush, the bench checks that the strobe drops after one cycle. It also checks that a change to an unrelated enable does not flush, that both strobes together follow the machine layout, and that a supervisor write with an illegal previous privilege keeps the old value.

// File: rtl/stat_filt_pkg.sv
`timescale 1ns/1ps
package stat_filt_pkg;

    // machine-layout field positions; widths of the multi-bit fields
    localparam int unsigned BIT_IE   = 0;
    localparam int unsigned BIT_PRV  = 1;
    localparam int unsigned BIT_IE1  = 3;
    localparam int unsigned BIT_PRV1 = 4;
    localparam int unsigned BIT_IE2  = 6;
    localparam int unsigned BIT_PRV2 = 7;
    localparam int unsigned BIT_FS   = 12;
    localparam int unsigned BIT_XS   = 14;
    localparam int unsigned BIT_MPRV = 16;
    localparam int unsigned BIT_VM   = 17;
    localparam int unsigned PRV_W    = 2;
    localparam int unsigned STW      = 2;
    localparam int unsigned VM_W     = 5;
    localparam int unsigned NUM_PRV  = 3;

    // supervisor-layout field positions
    localparam int unsigned SV_IE   = 0;
    localparam int unsigned SV_PIE  = 4;
    localparam int unsigned SV_PS   = 8;
    localparam int unsigned SV_FS   = 12;
    localparam int unsigned SV_XS   = 14;
    localparam int unsigned SV_MPRV = 16;

    localparam logic [PRV_W-1:0] PRV_USER = 2'd0;
    localparam logic [PRV_W-1:0] PRV_SUPV = 2'd1;
    localparam logic [PRV_W-1:0] PRV_MACH = 2'd3;

    localparam logic [VM_W-1:0] VM_BARE = 5'd0;
    localparam logic [VM_W-1:0] VM_SV32 = 5'd8;
    localparam logic [VM_W-1:0] VM_SV39 = 5'd9;
    localparam logic [VM_W-1:0] VM_SV48 = 5'd10;

    localparam logic [STW-1:0] ST_DIRTY = 2'b11;

    typedef struct packed {
        logic [VM_W-1:0]  vm;
        logic             mprv;
        logic [STW-1:0]   xs;
        logic [STW-1:0]   fs;
        logic [PRV_W-1:0] prv2;
        logic             ie2;
        logic [PRV_W-1:0] prv1;
        logic             ie1;
        logic [PRV_W-1:0] prv;
        logic             ie;
    } stat_fields_t;

    typedef enum logic [1:0] {
        WR_NONE = 2'd0,
        WR_MACH = 2'd1,
        WR_SUP  = 2'd2
    } wr_src_e;

    typedef enum logic {
        PH_QUIET = 1'b0,
        PH_FLUSH = 1'b1
    } flush_ph_e;

    localparam stat_fields_t STAT_RESET = '{
        vm:   VM_BARE,
        mprv: 1'b0,
        xs:   '0,
        fs:   '0,
        prv2: PRV_SUPV,
        ie2:  1'b0,
        prv1: PRV_SUPV,
        ie1:  1'b0,
        prv:  PRV_MACH,
        ie:   1'b0
    };

endpackage

// File: rtl/stat_legal_filter.sv
`timescale 1ns/1ps
module stat_legal_filter
    import stat_filt_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  stat_fields_t cur_i,
    input  stat_fields_t cand_i,
    input  logic         ext_i,
    output stat_fields_t next_o,
    output logic         xlat_chg_o
);

    logic [NUM_PRV-1:0][PRV_W-1:0] cur_p;
    logic [NUM_PRV-1:0][PRV_W-1:0] cand_p;
    logic [NUM_PRV-1:0][PRV_W-1:0] nxt_p;
    logic                          vm_ok;

    function automatic logic prv_ok(input logic [PRV_W-1:0] p);
        return (p == PRV_USER) || (p == PRV_SUPV) || (p == PRV_MACH);
    endfunction

    assign cur_p  = {cur_i.prv2, cur_i.prv1, cur_i.prv};
    assign cand_p = {cand_i.prv2, cand_i.prv1, cand_i.prv};

    // each privilege field is judged on its own
    for (genvar g = 0; g < NUM_PRV; g++) begin : g_prv
        assign nxt_p[g] = prv_ok(cand_p[g]) ? cand_p[g] : cur_p[g];
    end

    // translation-mode legality depends on the register width
    if (XLEN == 64) begin : g_vm64
        assign vm_ok = (cand_i.vm == VM_BARE) || (cand_i.vm == VM_SV39) ||
                       (cand_i.vm == VM_SV48);
    end else if (XLEN == 32) begin : g_vm32
        assign vm_ok = (cand_i.vm == VM_BARE) || (cand_i.vm == VM_SV32);
    end else begin : g_vmbare
        assign vm_ok = (cand_i.vm == VM_BARE);
    end

    always_comb begin
        next_o      = cur_i;
        next_o.ie   = cand_i.ie;
        next_o.ie1  = cand_i.ie1;
        next_o.ie2  = cand_i.ie2;
        next_o.mprv = cand_i.mprv;
        next_o.fs   = cand_i.fs;
        next_o.xs   = ext_i ? cand_i.xs : cur_i.xs;
        next_o.prv  = nxt_p[0];
        next_o.prv1 = nxt_p[1];
        next_o.prv2 = nxt_p[2];
        next_o.vm   = vm_ok ? cand_i.vm : cur_i.vm;
    end

    // requested change, judged on the unfiltered candidate
    assign xlat_chg_o = (cand_i.vm   != cur_i.vm)   ||
                        (cand_i.prv  != cur_i.prv)  ||
                        (cand_i.prv1 != cur_i.prv1) ||
                        (cand_i.mprv != cur_i.mprv);

endmodule

// File: rtl/stat_sview_map.sv
`timescale 1ns/1ps
module stat_sview_map
    import stat_filt_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  stat_fields_t    cur_i,
    input  logic            sd_i,
    input  logic [XLEN-1:0] wdata_i,
    output stat_fields_t    sup_cand_o,
    output logic [XLEN-1:0] sview_o
);

    logic unused_sv_bits;

    // supervisor write: rearrange into machine positions, rest untouched
    always_comb begin
        sup_cand_o      = cur_i;
        sup_cand_o.ie   = wdata_i[SV_IE];
        sup_cand_o.ie1  = wdata_i[SV_PIE];
        sup_cand_o.prv1 = wdata_i[SV_PS +: PRV_W];
        sup_cand_o.fs   = wdata_i[SV_FS +: STW];
        sup_cand_o.xs   = wdata_i[SV_XS +: STW];
        sup_cand_o.mprv = wdata_i[SV_MPRV];
    end

    // supervisor read view
    always_comb begin
        sview_o                   = '0;
        sview_o[SV_IE]            = cur_i.ie;
        sview_o[SV_PIE]           = cur_i.ie1;
        sview_o[SV_PS +: PRV_W]   = cur_i.prv1;
        sview_o[SV_FS +: STW]     = cur_i.fs;
        sview_o[SV_XS +: STW]     = cur_i.xs;
        sview_o[SV_MPRV]          = cur_i.mprv;
        sview_o[XLEN-1]           = sd_i;
    end

    assign unused_sv_bits = ^{wdata_i[XLEN-1:SV_MPRV+1], wdata_i[SV_FS-1:SV_PS+PRV_W],
                              wdata_i[SV_PS-1:SV_PIE+1], wdata_i[SV_PIE-1:SV_IE+1]};

endmodule

// File: rtl/stat_filter.sv
`timescale 1ns/1ps
module stat_filter
    import stat_filt_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] wdata_i,
    input  logic            mwr_i,
    input  logic            swr_i,
    input  logic            ext_present_i,
    output logic [XLEN-1:0] status_o,
    output logic [XLEN-1:0] sview_o,
    output logic            flush_o
);

    localparam int unsigned TOP_FIELD = BIT_VM + VM_W;

    wr_src_e      src;
    stat_fields_t cur_q;
    stat_fields_t mach_cand;
    stat_fields_t sup_cand;
    stat_fields_t cand;
    stat_fields_t nxt;
    logic         sd_q;
    logic         xlat_chg;
    logic         wr_any;
    logic         trig;
    flush_ph_e    ph_q;
    flush_ph_e    ph_d;
    logic         unused_wd_bits;

    // write-source decode; machine layout wins a tie
    always_comb begin
        if (mwr_i)      src = WR_MACH;
        else if (swr_i) src = WR_SUP;
        else            src = WR_NONE;
    end

    always_comb begin
        mach_cand.ie   = wdata_i[BIT_IE];
        mach_cand.prv  = wdata_i[BIT_PRV +: PRV_W];
        mach_cand.ie1  = wdata_i[BIT_IE1];
        mach_cand.prv1 = wdata_i[BIT_PRV1 +: PRV_W];
        mach_cand.ie2  = wdata_i[BIT_IE2];
        mach_cand.prv2 = wdata_i[BIT_PRV2 +: PRV_W];
        mach_cand.fs   = wdata_i[BIT_FS +: STW];
        mach_cand.xs   = wdata_i[BIT_XS +: STW];
        mach_cand.mprv = wdata_i[BIT_MPRV];
        mach_cand.vm   = wdata_i[BIT_VM +: VM_W];
    end

    assign unused_wd_bits = ^{wdata_i[XLEN-1:TOP_FIELD], wdata_i[BIT_FS-1:BIT_PRV2+PRV_W]};

    stat_sview_map #(.XLEN(XLEN)) u_sview (
        .cur_i      (cur_q),
        .sd_i       (sd_q),
        .wdata_i    (wdata_i),
        .sup_cand_o (sup_cand),
        .sview_o    (sview_o)
    );

    always_comb begin
        unique case (src)
            WR_MACH: cand = mach_cand;
            WR_SUP:  cand = sup_cand;
            default: cand = cur_q;
        endcase
    end

    stat_legal_filter #(.XLEN(XLEN)) u_filter (
        .cur_i      (cur_q),
        .cand_i     (cand),
        .ext_i      (ext_present_i),
        .next_o     (nxt),
        .xlat_chg_o (xlat_chg)
    );

    assign wr_any = (src != WR_NONE);
    assign trig   = wr_any && xlat_chg;

    // storage: fields and the derived dirty summary
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= STAT_RESET;
            sd_q  <= 1'b0;
        end else if (wr_any) begin
            cur_q <= nxt;
            sd_q  <= (nxt.fs == ST_DIRTY) || (nxt.xs == ST_DIRTY);
        end
    end

    // flush phase register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= PH_QUIET;
        else        ph_q <= ph_d;
    end

    always_comb begin
        unique case (ph_q)
            PH_QUIET: ph_d = trig ? PH_FLUSH : PH_QUIET;
            PH_FLUSH: ph_d = trig ? PH_FLUSH : PH_QUIET;
            default:  ph_d = PH_QUIET;
        endcase
    end

    // outputs
    always_comb begin
        status_o                       = '0;
        status_o[BIT_IE]               = cur_q.ie;
        status_o[BIT_PRV +: PRV_W]     = cur_q.prv;
        status_o[BIT_IE1]              = cur_q.ie1;
        status_o[BIT_PRV1 +: PRV_W]    = cur_q.prv1;
        status_o[BIT_IE2]              = cur_q.ie2;
        status_o[BIT_PRV2 +: PRV_W]    = cur_q.prv2;
        status_o[BIT_FS +: STW]        = cur_q.fs;
        status_o[BIT_XS +: STW]        = cur_q.xs;
        status_o[BIT_MPRV]             = cur_q.mprv;
        status_o[BIT_VM +: VM_W]       = cur_q.vm;
        status_o[XLEN-1]               = sd_q;
        flush_o                        = (ph_q == PH_FLUSH);
    end

endmodule

// File: rtl/stat_filt_chk.sv
`timescale 1ns/1ps
module stat_filt_chk
    import stat_filt_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] wdata_i,
    input logic            mwr_i,
    input logic            swr_i,
    input logic            ext_present_i,
    input logic [XLEN-1:0] status_o,
    input logic [XLEN-1:0] sview_o,
    input logic            flush_o
);

    logic [VM_W-1:0] vm_now;
    logic            vm_legal_now;

    assign vm_now       = status_o[BIT_VM +: VM_W];
    assign vm_legal_now = (vm_now == VM_BARE) ||
                          ((XLEN == 32) ? (vm_now == VM_SV32)
                                        : ((vm_now == VM_SV39) || (vm_now == VM_SV48)));

    // R4: stored privilege codes never hold the reserved encoding
    p_prv_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[BIT_PRV +: PRV_W] != 2'd2) && (status_o[BIT_PRV1 +: PRV_W] != 2'd2) &&
        (status_o[BIT_PRV2 +: PRV_W] != 2'd2));

    // R4: machine write of the reserved code keeps current privilege
    p_prv_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mwr_i && (wdata_i[BIT_PRV +: PRV_W] == 2'd2)) |=> $stable(status_o[BIT_PRV +: PRV_W]));

    // R3: extension state frozen when no extension is fitted
    p_xs_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((mwr_i || swr_i) && !ext_present_i) |=> $stable(status_o[BIT_XS +: STW]));

    // R5: translation mode always legal for the width
    p_vm_legal_r5: assert property (@(posedge clk) disable iff (!rst_n) vm_legal_now);

    // R6: dirty summary follows the state fields
    p_sd_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[XLEN-1] == ((status_o[BIT_FS +: STW] == ST_DIRTY) ||
                             (status_o[BIT_XS +: STW] == ST_DIRTY)));

    // R7: a flush is always caused by a write one cycle earlier
    p_flush_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> $past(mwr_i || swr_i));

    // R7: no write, no flush next cycle
    p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mwr_i || swr_i) |=> !flush_o);

    // R9: supervisor view mirrors the enables and previous privilege
    p_sview_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sview_o[SV_IE] == status_o[BIT_IE]) && (sview_o[SV_PIE] == status_o[BIT_IE1]) &&
        (sview_o[SV_PS +: PRV_W] == status_o[BIT_PRV1 +: PRV_W]));

    // R10: with both strobes, the machine layout decides the second-previous enable
    p_mach_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mwr_i && swr_i) |=> (status_o[BIT_IE2] == $past(wdata_i[BIT_IE2])));

endmodule

bind stat_filter stat_filt_chk #(.XLEN(XLEN)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wdata_i       (wdata_i),
    .mwr_i         (mwr_i),
    .swr_i         (swr_i),
    .ext_present_i (ext_present_i),
    .status_o      (status_o),
    .sview_o       (sview_o),
    .flush_o       (flush_o)
);

// File: tb/stat_filter_bench.sv
`timescale 1ns/1ps
module stat_filter_bench;

    localparam logic [63:0] FMASK = 64'h0000_0000_003F_F1FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] wdata_i = '0;
    logic        mwr_i = 1'b0;
    logic        swr_i = 1'b0;
    logic        ext_present_i = 1'b0;
    logic [63:0] status_o;
    logic [63:0] sview_o;
    logic        flush_o;

    int total = 0;
    int bad = 0;
    logic [63:0] e_st;   // expected fields, dirty bit excluded

    always #4 clk = ~clk;

    stat_filter #(.XLEN(64)) u_stat_filter (
        .clk(clk), .rst_n(rst_n), .wdata_i(wdata_i), .mwr_i(mwr_i), .swr_i(swr_i),
        .ext_present_i(ext_present_i), .status_o(status_o), .sview_o(sview_o),
        .flush_o(flush_o)
    );

    function automatic logic [63:0] with_sd(input logic [63:0] s);
        logic [63:0] r;
        r = s;
        r[63] = (s[13:12] == 2'b11) || (s[15:14] == 2'b11);
        return r;
    endfunction

    function automatic logic [63:0] sv_of(input logic [63:0] s);
        logic [63:0] v;
        v = '0;
        v[0] = s[0]; v[4] = s[3]; v[9:8] = s[5:4];
        v[13:12] = s[13:12]; v[15:14] = s[15:14]; v[16] = s[16];
        v[63] = with_sd(s)[63];
        return v;
    endfunction

    function automatic logic [1:0] pick_prv(input logic [1:0] n, input logic [1:0] o);
        return (n == 2'd2) ? o : n;
    endfunction

    task automatic check(input string req, input string what, input logic [63:0] act,
                         input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // drive one write cycle, update the expected model, check all outputs
    task automatic drive(input logic m, input logic s, input logic [63:0] d,
                         input logic x, input string req);
        logic [63:0] c;
        logic [63:0] n;
        logic        fl;
        @(negedge clk);
        mwr_i = m; swr_i = s; wdata_i = d; ext_present_i = x;
        if (m) c = d & FMASK;
        else begin
            c = e_st;
            c[0] = d[0]; c[3] = d[4]; c[5:4] = d[9:8];
            c[13:12] = d[13:12]; c[15:14] = d[15:14]; c[16] = d[16];
        end
        fl = (c[21:17] != e_st[21:17]) || (c[2:1] != e_st[2:1]) ||
             (c[5:4] != e_st[5:4]) || (c[16] != e_st[16]);
        n = e_st;
        n[0] = c[0]; n[3] = c[3]; n[6] = c[6]; n[16] = c[16]; n[13:12] = c[13:12];
        if (x) n[15:14] = c[15:14];
        n[2:1] = pick_prv(c[2:1], e_st[2:1]);
        n[5:4] = pick_prv(c[5:4], e_st[5:4]);
        n[8:7] = pick_prv(c[8:7], e_st[8:7]);
        if (c[21:17] == 5'd0 || c[21:17] == 5'd9 || c[21:17] == 5'd10) n[21:17] = c[21:17];
        e_st = n;
        @(negedge clk);
        mwr_i = 1'b0; swr_i = 1'b0;
        check(req, "status", status_o, with_sd(e_st));
        check(req, "sview", sview_o, sv_of(e_st));
        check(req, "flush", {63'd0, flush_o}, {63'd0, fl});
    endtask

    task automatic t_reset();
        check("R1", "status", status_o, 64'h96);
        check("R1", "sview", sview_o, 64'h100);
        check("R1", "flush", {63'd0, flush_o}, 64'd0);
    endtask

    task automatic t_direct();
        // R2: enables, modified-privilege and FP state written directly
        drive(1'b1, 1'b0, 64'h0001_2000 | 64'h49 | 64'h96, 1'b0, "R2");
        drive(1'b1, 1'b0, 64'h96 | 64'h1000, 1'b0, "R2");
    endtask

    task automatic t_xs();
        drive(1'b1, 1'b0, e_st | 64'hC000, 1'b0, "R3");
        check("R3", "xs", {62'd0, status_o[15:14]}, 64'd0);
        drive(1'b1, 1'b0, e_st | 64'hC000, 1'b1, "R3");
        check("R3", "xs", {62'd0, status_o[15:14]}, 64'd3);
    endtask

    task automatic t_prv();
        // R4: current=2 (kept), previous=0 (taken), second-previous=2 (kept)
        drive(1'b1, 1'b0, (e_st & ~64'h1B6) | 64'h4 | 64'h100, 1'b0, "R4");
        check("R4", "prv", {62'd0, status_o[2:1]}, 64'd3);
        check("R4", "prv1", {62'd0, status_o[5:4]}, 64'd0);
        check("R4", "prv2", {62'd0, status_o[8:7]}, 64'd1);
        drive(1'b1, 1'b0, (e_st & ~64'h1B6) | 64'h2 | 64'h10 | 64'h180, 1'b0, "R4");
    endtask

    task automatic t_vm();
        drive(1'b1, 1'b0, (e_st & ~64'h3E_0000) | (64'd8 << 17), 1'b0, "R5");
        check("R5", "vm sv32 at xlen64", {59'd0, status_o[21:17]}, 64'd0);
        drive(1'b1, 1'b0, (e_st & ~64'h3E_0000) | (64'd9 << 17), 1'b0, "R5");
        drive(1'b1, 1'b0, (e_st & ~64'h3E_0000) | (64'd10 << 17), 1'b0, "R5");
        drive(1'b1, 1'b0, (e_st & ~64'h3E_0000) | (64'd31 << 17), 1'b0, "R5");
        check("R5", "vm illegal", {59'd0, status_o[21:17]}, 64'd10);
        drive(1'b1, 1'b0, e_st & ~64'h3E_0000, 1'b0, "R5");
    endtask

    task automatic t_sd();
        drive(1'b1, 1'b0, (e_st & ~64'hF000) | 64'h3000, 1'b1, "R6");
        check("R6", "sd set", {63'd0, status_o[63]}, 64'd1);
        drive(1'b1, 1'b0, (e_st & ~64'hF000) | 64'h1000 | (64'd1 << 63) | (64'd1 << 30)
              | 64'h800, 1'b1, "R6");
        check("R6", "sd and reserved", status_o & ~FMASK, 64'd0);
    endtask

    task automatic t_flush();
        drive(1'b1, 1'b0, e_st, 1'b0, "R7 same value");
        drive(1'b1, 1'b0, e_st ^ 64'h1, 1'b0, "R7 enable only");
        drive(1'b1, 1'b0, (e_st & ~64'h3E_0000) | (64'd9 << 17), 1'b0, "R7 mode change");
        @(negedge clk);
        check("R7", "flush drop", {63'd0, flush_o}, 64'd0);
        // requested reserved privilege still counts as a requested change
        drive(1'b1, 1'b0, (e_st & ~64'h6) | 64'h4, 1'b0, "R7 raw request");
        @(negedge clk);
        check("R7", "flush drop", {63'd0, flush_o}, 64'd0);
    endtask

    task automatic t_sup();
        // R8: ie, pie, ps=3, fs=2, xs=1; bits 1..2 and 6 must not reach machine fields
        drive(1'b0, 1'b1, 64'h0001_0000 | 64'h6000 | 64'h300 | 64'h11 | 64'h46, 1'b1, "R8");
        check("R8", "prv untouched", {62'd0, status_o[2:1]}, {62'd0, e_st[2:1]});
        drive(1'b0, 1'b1, 64'h200, 1'b1, "R8 illegal ps");
        check("R8", "prv1 kept", {62'd0, status_o[5:4]}, 64'd3);
        check("R9", "sview ps", {62'd0, sview_o[9:8]}, 64'd3);
        drive(1'b0, 1'b1, 64'h3100, 1'b0, "R9");
        check("R9", "sview sd", {63'd0, sview_o[63]}, 64'd1);
    endtask

    task automatic t_both();
        drive(1'b1, 1'b1, 64'h40 | 64'h96, 1'b0, "R10");
        check("R10", "ie2 from machine layout", {63'd0, status_o[6]}, 64'd1);
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        e_st = 64'h96;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direct();
        t_xs();
        t_prv();
        t_vm();
        t_sd();
        t_flush();
        t_sup();
        t_both();
        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule